// File: doc/BRIEF.md
# Indexed Interrupt Routing Register Window

This block holds the routing table of an interrupt redirection unit and lets a processor reach it through a narrow bus port. Software first writes an index into a select register. It then reads or writes one 32-bit word of the selected register through a data window. Behind the window there are an identification register, a version register, an arbitration register and one 64-bit routing entry per interrupt pin. Each routing entry is reached as a lower and an upper 32-bit half.

The whole table leaves the block as a flat vector for the delivery logic beside it. That logic reports back, per pin, when a level-triggered interrupt has been accepted, and the block then sets the entry's remote-IRR bit. Every accepted table write emits a one-cycle service-request pulse so that the delivery logic rescans the table. When the version parameter is 0x20, an end-of-interrupt register is also decoded. A write to it emits a strobe carrying the vector, and it clears remote-IRR in every entry that holds that vector.

Top module: `irq_route_window`

## Requirements
- R1: Only address bits 7:0 are decoded. The select register sits at offset 0x00 and accepts reads and writes of any size; the window sits at 0x10 and the end-of-interrupt register at 0x40. Read data appears on `bus_rdata` with `bus_rvalid` one cycle after `bus_rd`. Reading the select register returns its 8-bit value zero-extended.
- R2: A window or end-of-interrupt access whose `bus_size` is not 4 has no effect, and a window read of that kind returns 0.
- R3: For a select value S of 0x10 or more, the entry index is (S−0x10)>>1. An odd S reaches entry bits 63:32 and an even S reaches bits 31:0. An index of NUM_PINS or more reads 0, and writes to it are ignored.
- R4: Select 0x01 reads VERSION in bits 7:0 and NUM_PINS−1 in bits 23:16, with all other bits 0. Writes to it are ignored.
- R5: A window write with select 0x00 stores data bits 27:24 as the ID. Selects 0x00 and 0x02 both read the ID in bits 27:24. Writes with select 0x02 are ignored.
- R6: A table write keeps the previous values of delivery status (bit 12) and remote-IRR (bit 14); every other bit takes the written data.
- R7: Whenever an entry's trigger bit (bit 15) is 0 (edge), its remote-IRR bit is 0, including right after a write that selects edge.
- R8: `svc_req` pulses high in the cycle after each accepted table write, and at no other time.
- R9: With VERSION 0x20, a 4-byte write to 0x40 raises `eoi_valid` for one cycle with `eoi_vector` = data bits 7:0, and it clears remote-IRR in every entry whose vector (bits 7:0) matches. With VERSION 0x11 the register does nothing. Only 0x11 and 0x20 are legal.
- R10: A pulse on `rirr_set[i]` sets remote-IRR of entry i when that entry is level-triggered (bit 15 = 1). On an edge-triggered entry it has no effect.
- R11: After reset every entry holds 0x0000_0000_0001_0000 (mask bit 16 set), and the select register and ID are 0.
- R12: `rte_flat[64*i +: 64]` always shows entry i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address within the 4 KiB region |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_size | input | 3 | Access width in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| rirr_set | input | NUM_PINS | Per-pin acceptance of a level interrupt |
| rte_flat | output | 64*NUM_PINS | All routing entries, entry i at 64*i |
| eoi_valid | output | 1 | End-of-interrupt strobe |
| eoi_vector | output | 8 | Vector of the end-of-interrupt |
| svc_req | output | 1 | Service request after a table write |

## Verification
The bench drives two instances from one bus. The first uses the default 24 pins and VERSION 0x20. There the end-of-interrupt path, its clearing of remote-IRR and the top entry 23 can all be reached. The second uses 8 pins and VERSION 0x11. That exposes a different version word, shows the end-of-interrupt register silent, and makes select 0x20 an out-of-range index that is cheap to hit.

// File: rtl/irw_pkg.sv
package irw_pkg;

  localparam int ENT_W    = 64;
  localparam int B_DSTAT  = 12;
  localparam int B_RIRR   = 14;
  localparam int B_TRIG   = 15;
  localparam int B_MASK   = 16;

  localparam logic [ENT_W-1:0] RO_MASK     = (64'd1 << B_DSTAT) | (64'd1 << B_RIRR);
  localparam logic [ENT_W-1:0] RESET_ENTRY = 64'd1 << B_MASK;

  localparam logic [7:0] OFF_SEL = 8'h00;
  localparam logic [7:0] OFF_WIN = 8'h10;
  localparam logic [7:0] OFF_EOI = 8'h40;

  localparam logic [7:0] IX_ID  = 8'h00;
  localparam logic [7:0] IX_VER = 8'h01;
  localparam logic [7:0] IX_ARB = 8'h02;
  localparam logic [7:0] IX_TBL = 8'h10;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_ID,
    TGT_VER,
    TGT_ARB,
    TGT_TBL
  } win_tgt_e;

  typedef struct packed {
    logic sel_wr;
    logic sel_rd;
    logic win_wr;
    logic win_rd;
    logic eoi_wr;
  } acc_t;

  function automatic logic [ENT_W-1:0] merge_half(
    input logic [ENT_W-1:0] cur,
    input logic [31:0]      wdata,
    input logic             hi
  );
    logic [ENT_W-1:0] m;
    m = hi ? {wdata, cur[31:0]} : {cur[63:32], wdata};
    return (m & ~RO_MASK) | (cur & RO_MASK);
  endfunction

  function automatic logic [31:0] version_word(input logic [7:0] ver, input int pins);
    logic [7:0] top;
    top = 8'(pins - 1);
    return {8'h00, top, 8'h00, ver};
  endfunction

  function automatic logic [31:0] id_word(input logic [3:0] id);
    return {4'h0, id, 24'h000000};
  endfunction

endpackage

// File: rtl/irw_decode.sv
module irw_decode
  import irw_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = 5
) (
  input  logic [7:0]       addr,
  input  logic             wr,
  input  logic             rd,
  input  logic [2:0]       size,
  input  logic [7:0]       sel,
  output acc_t             acc,
  output win_tgt_e         tgt,
  output logic [IDX_W-1:0] idx,
  output logic             hi
);
  logic       word;
  logic [7:0] off;
  logic [7:0] raw;

  assign word = (size == 3'd4);
  assign off  = sel - IX_TBL;
  assign raw  = {1'b0, off[7:1]};
  assign idx  = raw[IDX_W-1:0];
  assign hi   = sel[0];

  always_comb begin
    acc.sel_wr = wr && (addr == OFF_SEL);
    acc.sel_rd = rd && (addr == OFF_SEL);
    acc.win_wr = wr && (addr == OFF_WIN) && word;
    acc.win_rd = rd && (addr == OFF_WIN) && word;
    acc.eoi_wr = wr && (addr == OFF_EOI) && word;
  end

  always_comb begin
    unique case (sel)
      IX_ID:   tgt = TGT_ID;
      IX_VER:  tgt = TGT_VER;
      IX_ARB:  tgt = TGT_ARB;
      default: tgt = ((sel >= IX_TBL) && (raw < 8'(NUM_PINS))) ? TGT_TBL : TGT_NONE;
    endcase
  end
endmodule

// File: rtl/irw_entry.sv
module irw_entry
  import irw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_hi,
  input  logic [31:0]      wdata,
  input  logic             eoi_en,
  input  logic [7:0]       eoi_vec,
  input  logic             rirr_set,
  output logic [ENT_W-1:0] entry_q
);
  logic [ENT_W-1:0] nxt;
  logic             eoi_hit;

  assign eoi_hit = eoi_en && entry_q[B_RIRR] && (entry_q[7:0] == eoi_vec);

  always_comb begin
    nxt = entry_q;
    if (wr_en)                  nxt = merge_half(entry_q, wdata, wr_hi);
    if (eoi_hit)                nxt[B_RIRR] = 1'b0;
    if (rirr_set && nxt[B_TRIG]) nxt[B_RIRR] = 1'b1;
    if (!nxt[B_TRIG])           nxt[B_RIRR] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) entry_q <= RESET_ENTRY;
    else        entry_q <= nxt;
  end

  // R7: an edge entry never holds remote-IRR
  a_r7_edge_no_rirr: assert property (@(posedge clk) disable iff (!rst_n)
    !entry_q[B_TRIG] |-> !entry_q[B_RIRR]);

  // R6: delivery status survives a write
  a_r6_dstat_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> entry_q[B_DSTAT] == $past(entry_q[B_DSTAT]));

  // R9: a matching end-of-interrupt clears remote-IRR
  a_r9_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_hit && !wr_en && !rirr_set) |=> !entry_q[B_RIRR]);
endmodule

// File: rtl/irw_rdmux.sv
module irw_rdmux
  import irw_pkg::*;
#(
  parameter int         NUM_PINS = 24,
  parameter int         IDX_W    = 5,
  parameter logic [7:0] VERSION  = 8'h20
) (
  input  acc_t                      acc,
  input  win_tgt_e                  tgt,
  input  logic [IDX_W-1:0]          idx,
  input  logic                      hi,
  input  logic [7:0]                sel,
  input  logic [3:0]                id,
  input  logic [NUM_PINS*ENT_W-1:0] tbl,
  output logic [31:0]               rdata_d
);
  logic [ENT_W-1:0] ent;

  assign ent = tbl[idx*ENT_W +: ENT_W];

  always_comb begin
    rdata_d = 32'h0;
    if (acc.sel_rd) begin
      rdata_d = {24'h0, sel};
    end else if (acc.win_rd) begin
      unique case (tgt)
        TGT_ID, TGT_ARB: rdata_d = id_word(id);
        TGT_VER:         rdata_d = version_word(VERSION, NUM_PINS);
        TGT_TBL:         rdata_d = hi ? ent[63:32] : ent[31:0];
        default:         rdata_d = 32'h0;
      endcase
    end
  end
endmodule

// File: rtl/irq_route_window.sv
module irq_route_window
  import irw_pkg::*;
#(
  parameter int         NUM_PINS = 24,
  parameter logic [7:0] VERSION  = 8'h20,
  parameter int         ADDR_W   = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [2:0]                bus_size,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  output logic                      bus_rvalid,
  input  logic [NUM_PINS-1:0]       rirr_set,
  output logic [NUM_PINS*64-1:0]    rte_flat,
  output logic                      eoi_valid,
  output logic [7:0]                eoi_vector,
  output logic                      svc_req
);
  localparam int IDX_W  = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam bit EOI_EN = (VERSION == 8'h20);

  initial begin
    a_r9_version_legal: assert (VERSION == 8'h11 || VERSION == 8'h20);
  end

  logic [7:0]       sel_q;
  logic [3:0]       id_q;
  acc_t             acc;
  win_tgt_e         tgt;
  logic [IDX_W-1:0] idx;
  logic             hi;
  logic [31:0]      rdata_d;

  // named internal events
  logic tbl_wr_any;
  logic id_wr;
  logic eoi_fire;

  assign tbl_wr_any = acc.win_wr && (tgt == TGT_TBL);
  assign id_wr      = acc.win_wr && (tgt == TGT_ID);
  assign eoi_fire   = acc.eoi_wr && EOI_EN;

  irw_decode #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_dec (
    .addr (bus_addr[7:0]),
    .wr   (bus_wr),
    .rd   (bus_rd),
    .size (bus_size),
    .sel  (sel_q),
    .acc  (acc),
    .tgt  (tgt),
    .idx  (idx),
    .hi   (hi)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
    logic we;
    assign we = tbl_wr_any && (idx == IDX_W'(g));
    irw_entry u_ent (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (we),
      .wr_hi    (hi),
      .wdata    (bus_wdata),
      .eoi_en   (eoi_fire),
      .eoi_vec  (bus_wdata[7:0]),
      .rirr_set (rirr_set[g]),
      .entry_q  (rte_flat[g*64 +: 64])
    );
  end

  irw_rdmux #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W), .VERSION(VERSION)) u_rd (
    .acc     (acc),
    .tgt     (tgt),
    .idx     (idx),
    .hi      (hi),
    .sel     (sel_q),
    .id      (id_q),
    .tbl     (rte_flat),
    .rdata_d (rdata_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q      <= '0;
      id_q       <= '0;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      eoi_valid  <= 1'b0;
      eoi_vector <= '0;
      svc_req    <= 1'b0;
    end else begin
      if (acc.sel_wr) sel_q <= bus_wdata[7:0];
      if (id_wr)      id_q  <= bus_wdata[27:24];
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rdata_d;
      eoi_valid <= eoi_fire;
      if (eoi_fire) eoi_vector <= bus_wdata[7:0];
      svc_req <= tbl_wr_any;
    end
  end

  a_r1_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  a_r2_narrow_win_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[7:0] == OFF_WIN && bus_size != 3'd4) |=> bus_rdata == 32'h0);

  a_r8_svc_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wr_any |=> svc_req);

  a_r8_svc_only_write: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |-> $past(tbl_wr_any));

  a_r9_eoi_source: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |-> $past(bus_wr && bus_addr[7:0] == OFF_EOI && bus_size == 3'd4));

  a_r5_id_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !id_wr |=> $stable(id_q));
endmodule

// File: tb/irq_route_window_bench.sv
module irq_route_window_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [11:0]     addr = '0;
  logic            wr = 1'b0, rd = 1'b0;
  logic [2:0]      size = 3'd4;
  logic [31:0]     wdata = '0;
  logic [23:0]     rset_a = '0;
  logic [7:0]      rset_b = '0;
  logic [31:0]     rdata_a, rdata_b;
  logic            rv_a, rv_b;
  logic [24*64-1:0] tbl_a;
  logic [8*64-1:0] tbl_b;
  logic            eoi_a, eoi_b, svc_a, svc_b;
  logic [7:0]      eoiv_a, eoiv_b;

  irq_route_window u_irq_route_window (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
    .bus_size(size), .bus_wdata(wdata), .bus_rdata(rdata_a), .bus_rvalid(rv_a),
    .rirr_set(rset_a), .rte_flat(tbl_a), .eoi_valid(eoi_a), .eoi_vector(eoiv_a),
    .svc_req(svc_a));

  irq_route_window #(.NUM_PINS(8), .VERSION(8'h11)) u_small (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
    .bus_size(size), .bus_wdata(wdata), .bus_rdata(rdata_b), .bus_rvalid(rv_b),
    .rirr_set(rset_b), .rte_flat(tbl_b), .eoi_valid(eoi_b), .eoi_vector(eoiv_b),
    .svc_req(svc_b));

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] exp_a;
    bit          use_b;
    logic [31:0] exp_b;
    string       tag;
  } rd_item_t;
  rd_item_t q[$];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data
  always @(negedge clk) begin
    if (rst_n && rv_a) begin
      if (q.size() == 0) begin
        chk("R1 unexpected rvalid", 64'd1, 64'd0);
      end else begin
        rd_item_t it;
        it = q.pop_front();
        chk(it.tag, {32'h0, rdata_a}, {32'h0, it.exp_a});
        if (it.use_b) chk({it.tag, " small"}, {32'h0, rdata_b}, {32'h0, it.exp_b});
      end
    end
  end

  task automatic bus_write(logic [11:0] a, logic [2:0] s, logic [31:0] d,
                           bit exp_svc, string tag);
    addr = a; size = s; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    chk({tag, " R8 svc"}, {63'h0, svc_a}, {63'h0, exp_svc});
  endtask

  task automatic bus_read(logic [11:0] a, logic [2:0] s, logic [31:0] ea,
                          bit ub, logic [31:0] eb, string tag);
    rd_item_t it;
    it.exp_a = ea; it.use_b = ub; it.exp_b = eb; it.tag = tag;
    q.push_back(it);
    addr = a; size = s; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  function automatic logic [63:0] ent_a(int i);
    return tbl_a[i*64 +: 64];
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 / R12 reset state
    chk("R11 entry0", ent_a(0), 64'h0000_0000_0001_0000);
    chk("R12 entry23", ent_a(23), 64'h0000_0000_0001_0000);
    bus_read(12'h000, 3'd4, 32'h0, 1, 32'h0, "R11 select zero");
    bus_read(12'h010, 3'd4, 32'h0, 1, 32'h0, "R11 id zero");
    bus_write(12'h000, 3'd4, 32'h10, 0, "sel 0x10");
    bus_read(12'h010, 3'd4, 32'h0001_0000, 1, 32'h0001_0000, "R11 entry0 low masked");

    // R4 version words
    bus_write(12'h000, 3'd1, 32'h01, 0, "R1 sel byte write");
    bus_read(12'h000, 3'd1, 32'h01, 1, 32'h01, "R1 select readback");
    bus_read(12'h010, 3'd4, 32'h0017_0020, 1, 32'h0007_0011, "R4 version");
    bus_write(12'h010, 3'd4, 32'hFFFF_FFFF, 0, "R4 ver write");
    bus_read(12'h010, 3'd4, 32'h0017_0020, 1, 32'h0007_0011, "R4 version unchanged");

    // R5 ID and arbitration
    bus_write(12'h000, 3'd4, 32'h00, 0, "sel id");
    bus_write(12'h010, 3'd4, 32'hFA00_0000, 0, "R5 id write");
    bus_read(12'h010, 3'd4, 32'h0A00_0000, 0, 0, "R5 id read");
    bus_write(12'h000, 3'd4, 32'h02, 0, "sel arb");
    bus_write(12'h010, 3'd4, 32'h0500_0000, 0, "R5 arb write");
    bus_read(12'h010, 3'd4, 32'h0A00_0000, 0, 0, "R5 arb reads id");

    // R3/R6 entry 1
    bus_write(12'h000, 3'd4, 32'h12, 0, "sel e1 lo");
    bus_write(12'h010, 3'd4, 32'h0000_F031, 1, "R6 e1 write");
    chk("R6 R12 e1 low", ent_a(1), 64'h0000_0000_0000_A031);
    bus_read(12'h010, 3'd4, 32'h0000_A031, 0, 0, "R6 e1 readback");
    bus_write(12'h000, 3'd4, 32'h13, 0, "sel e1 hi");
    bus_write(12'h010, 3'd4, 32'hFE00_0000, 1, "R3 e1 hi write");
    bus_read(12'h010, 3'd4, 32'hFE00_0000, 0, 0, "R3 e1 upper");
    chk("R3 e1 both halves", ent_a(1), 64'hFE00_0000_0000_A031);

    // R10 remote-IRR from delivery side
    rset_a[1] = 1'b1; rset_a[2] = 1'b1;
    @(negedge clk);
    rset_a = '0;
    chk("R10 level set", ent_a(1), 64'hFE00_0000_0000_E031);
    chk("R10 edge ignored", ent_a(2), 64'h0000_0000_0001_0000);

    // R6 RO kept when writing zero there
    bus_write(12'h000, 3'd4, 32'h12, 0, "sel e1 lo");
    bus_write(12'h010, 3'd4, 32'h0000_A031, 1, "R6 rewrite");
    chk("R6 rirr kept", ent_a(1), 64'hFE00_0000_0000_E031);

    // R9 eoi mismatch then match
    bus_write(12'h040, 3'd4, 32'h55, 0, "R9 eoi other");
    chk("R9 eoi strobe", {55'h0, eoi_a, eoiv_a}, {55'h0, 1'b1, 8'h55});
    chk("R9 mismatch keeps rirr", ent_a(1), 64'hFE00_0000_0000_E031);
    bus_write(12'h040, 3'd2, 32'h31, 0, "R2 narrow eoi");
    chk("R2 narrow eoi no strobe", {63'h0, eoi_a}, 64'h0);
    chk("R2 narrow eoi rirr", ent_a(1), 64'hFE00_0000_0000_E031);
    bus_write(12'h040, 3'd4, 32'h31, 0, "R9 eoi match");
    chk("R9 eoi strobe match", {55'h0, eoi_a, eoiv_a}, {55'h0, 1'b1, 8'h31});
    chk("R9 small silent", {63'h0, eoi_b}, 64'h0);
    chk("R9 rirr cleared", ent_a(1), 64'hFE00_0000_0000_A031);

    // R7 edge forces remote-IRR to zero
    rset_a[1] = 1'b1;
    @(negedge clk);
    rset_a = '0;
    bus_write(12'h010, 3'd4, 32'h0000_2031, 1, "R7 edge write");
    chk("R7 rirr forced", ent_a(1), 64'hFE00_0000_0000_2031);

    // R2 narrow window
    bus_write(12'h010, 3'd2, 32'h0000_0000, 0, "R2 narrow write");
    chk("R2 narrow write ignored", ent_a(1), 64'hFE00_0000_0000_2031);
    bus_read(12'h010, 3'd2, 32'h0, 0, 0, "R2 narrow read");

    // R3 range
    bus_write(12'h000, 3'd4, 32'h3E, 0, "sel e23");
    bus_write(12'h010, 3'd4, 32'h0000_0077, 1, "R3 e23 write");
    chk("R3 e23", ent_a(23), 64'h0000_0000_0000_0077);
    bus_write(12'h000, 3'd4, 32'h40, 0, "sel idx24");
    bus_write(12'h010, 3'd4, 32'h0000_0099, 0, "R3 out of range write");
    bus_read(12'h010, 3'd4, 32'h0, 0, 0, "R3 out of range read");
    bus_write(12'h000, 3'd4, 32'h20, 0, "sel idx8");
    bus_read(12'h010, 3'd4, 32'h0001_0000, 1, 32'h0, "R3 small idx8 zero");

    // R1 upper address bits not decoded
    bus_write(12'h700, 3'd4, 32'h01, 0, "R1 alias sel");
    bus_read(12'hF10, 3'd4, 32'h0017_0020, 1, 32'h0007_0011, "R1 alias window");

    @(negedge clk);
    chk("R1 queue drained", 64'(q.size()), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule